// File: doc/BRIEF.md
# Addressable Full-Duplex Serial Port

This block is an asynchronous serial port with two independent halves. The transmitter sends one frame per accepted word. The receiver recovers frames from the line and hands them to the core. Both halves run from one external bit-rate enable, `tick`, which pulses sixteen times per bit period. A frame is a low start bit, eight data bits sent least significant bit first, an optional ninth bit (in nine-bit mode), and a high stop bit.

The receive path has two stages: a shift stage and a holding stage. A new frame can be recovered while the previous word waits in the holding stage. In nine-bit mode the port can filter for multiprocessor addressing. When filtering is on, the receiver stores only address frames, which have the ninth bit set. It also requires that the byte matches the node address on every bit selected by the mask, or that the byte is all ones on those bits (broadcast). All other frames are dropped silently. Core software normally turns filtering off after it has been addressed, so that the data frames that follow are received.

Stream rules: the transmit side is valid/ready. A word is taken on a clock edge where `tx_valid` and `tx_ready` are both high, and `tx_ready` stays low until the stop bit has been sent. The receive side is valid/ready as well. `rx_valid` with `rx_data`, `rx_bit9` and `rx_frame_err` stays constant until a clock edge with `rx_ready` high. The receiver cannot stall the line. Back-pressure therefore shows as loss: a frame that completes while the holding stage is still full is discarded.

Top module: `mpuart_port`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1, `tx_done` is 0 and `rx_valid` is 0.
- R2: An accepted word is sent as a 0 start bit, `tx_data` least significant bit first, then `tx_bit9` only when `cfg_nine` is 1, then a 1 stop bit. Each bit lasts 16 ticks, and `txd` is 1 whenever the transmitter is idle.
- R3: `tx_ready` is low from the edge after acceptance until the stop bit ends. `tx_done` then rises, and it is cleared by the next acceptance.
- R4: In eight-bit mode a received frame appears on `rx_data`, with `rx_bit9` equal to 0.
- R5: In nine-bit mode the received ninth bit appears on `rx_bit9`.
- R6: Each bit is decided by the majority of three samples around mid-bit. An inverted level lasting one tick at mid-bit does not change the received value.
- R7: A low pulse on `rxd` that is high again by mid start bit produces no frame, and the receiver accepts the next valid frame.
- R8: A frame whose stop bit samples as 0 is delivered with `rx_frame_err` set. A frame with a good stop bit has `rx_frame_err` at 0.
- R9: A frame can shift in while an earlier word is held. If the held word is taken before the new frame completes, the new frame is delivered.
- R10: A frame that completes while `rx_valid` is still 1 is discarded, and the held word is unchanged.
- R11: With `cfg_mp_en` and `cfg_nine` both 1, a frame is stored only if its ninth bit is 1 and `(byte ^ cfg_addr) & cfg_mask` is zero (or R12 holds). Frames with ninth bit 0 and frames that do not match are dropped.
- R12: With filtering on, an address frame whose byte has all `cfg_mask` bits set is accepted as broadcast.
- R13: While `rx_valid` is 1 and `rx_ready` is 0, `rx_valid` stays 1 and `rx_data` holds its value.
- R14: Transmission and reception proceed at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Oversampling enable, 16 per bit |
| cfg_nine | input | 1 | 1 selects nine-bit frames |
| cfg_mp_en | input | 1 | Address filtering enable (nine-bit mode only) |
| cfg_addr | input | 8 | Node address |
| cfg_mask | input | 8 | Address compare mask, 1 = compared |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmitter idle, word can be taken |
| tx_data | input | 8 | Transmit byte |
| tx_bit9 | input | 1 | Ninth bit to send |
| tx_done | output | 1 | Last frame fully sent |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_valid | output | 1 | Held word available |
| rx_ready | input | 1 | Core takes held word |
| rx_data | output | 8 | Received byte |
| rx_bit9 | output | 1 | Received ninth bit |
| rx_frame_err | output | 1 | Held word had a bad stop bit |

## Verification
The assertions assume that `cfg_nine`, `cfg_mp_en`, `cfg_addr` and `cfg_mask` change only while both halves are idle and no word is held. The filtering check relates a newly raised `rx_valid` to the present configuration, so it depends on this. The stimulus changes configuration only between scenarios, after the line has been idle for several bit times and the held word has been taken. It pulses `tick` every second clock, so that the oversampling counters move on enables rather than on clocks.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/mpuart_tx.sv
module mpuart_tx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              nine,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_bit9,
  output logic              tx_done,
  output logic              txd
);
  localparam int CW  = $clog2(OSR);
  localparam int FW  = DATA_W + 3;
  localparam int BCW = $clog2(FW + 1);

  logic          busy;
  logic [FW-1:0] shreg;
  logic [CW-1:0] tcnt;
  logic [BCW-1:0] bcnt, last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      shreg   <= '1;
      tcnt    <= '0;
      bcnt    <= '0;
      last    <= '0;
      tx_done <= 1'b0;
    end else if (tx_valid && !busy) begin
      busy    <= 1'b1;
      tx_done <= 1'b0;
      shreg   <= {1'b1, (nine ? tx_bit9 : 1'b1), tx_data, 1'b0};
      last    <= nine ? BCW'(FW - 1) : BCW'(FW - 2);
      tcnt    <= '0;
      bcnt    <= '0;
    end else if (busy && tick) begin
      tcnt <= tcnt + 1'b1;
      if (tcnt == CW'(OSR - 1)) begin
        tcnt  <= '0;
        shreg <= {1'b1, shreg[FW-1:1]};
        bcnt  <= bcnt + 1'b1;
        if (bcnt == last) begin
          busy    <= 1'b0;
          tx_done <= 1'b1;
        end
      end
    end
  end

  assign tx_ready = !busy;
  assign txd      = shreg[0];

  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  a_r3_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> (tx_ready && txd));
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
  import mpuart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              nine,
  output logic              fr_done,
  output logic [DATA_W-1:0] fr_data,
  output logic              fr_b9,
  output logic              fr_err
);
  localparam int CW  = $clog2(OSR);
  localparam int BCW = $clog2(DATA_W + 2);
  localparam int S0  = OSR / 2 - 1;
  localparam int S1  = OSR / 2;
  localparam int S2  = OSR / 2 + 1;

  rx_state_e     state;
  logic          r_meta, r_sync;
  logic [CW-1:0] tcnt;
  logic [BCW-1:0] bcnt;
  logic          s_a, s_b, nine_q;
  logic [DATA_W:0] sh;
  logic          vote;

  assign vote = maj3(s_a, s_b, r_sync);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_meta <= 1'b1;
      r_sync <= 1'b1;
    end else begin
      r_meta <= rxd;
      r_sync <= r_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      tcnt    <= '0;
      bcnt    <= '0;
      s_a     <= 1'b1;
      s_b     <= 1'b1;
      nine_q  <= 1'b0;
      sh      <= '0;
      fr_done <= 1'b0;
      fr_data <= '0;
      fr_b9   <= 1'b0;
      fr_err  <= 1'b0;
    end else begin
      fr_done <= 1'b0;
      if (state == RX_IDLE) begin
        if (tick && !r_sync) begin
          state  <= RX_START;
          tcnt   <= CW'(1);
          nine_q <= nine;
        end
      end else if (tick) begin
        tcnt <= tcnt + 1'b1;
        if (tcnt == CW'(S0)) s_a <= r_sync;
        if (tcnt == CW'(S1)) s_b <= r_sync;
        if (state == RX_START) begin
          if (tcnt == CW'(S2) && vote) state <= RX_IDLE;
          else if (tcnt == CW'(OSR - 1)) begin
            state <= RX_BITS;
            bcnt  <= '0;
          end
        end else if (state == RX_BITS) begin
          if (tcnt == CW'(S2)) sh <= {vote, sh[DATA_W:1]};
          else if (tcnt == CW'(OSR - 1)) begin
            bcnt <= bcnt + 1'b1;
            if (bcnt == (nine_q ? BCW'(DATA_W) : BCW'(DATA_W - 1))) state <= RX_STOP;
          end
        end else begin
          if (tcnt == CW'(S2)) begin
            fr_done <= 1'b1;
            fr_err  <= !vote;
            fr_data <= nine_q ? sh[DATA_W-1:0] : sh[DATA_W:1];
            fr_b9   <= nine_q & sh[DATA_W];
            state   <= RX_IDLE;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mpuart_addr_filter.sv
module mpuart_addr_filter #(
  parameter int DATA_W = 8
) (
  input  logic              mp_active,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              b9_in,
  input  logic [DATA_W-1:0] node_addr,
  input  logic [DATA_W-1:0] node_mask,
  output logic              accept
);
  logic hit, bcast;

  always_comb begin
    hit    = ((byte_in ^ node_addr) & node_mask) == '0;
    bcast  = (byte_in & node_mask) == node_mask;
    accept = !mp_active || (b9_in && (hit || bcast));
  end
endmodule

// File: rtl/mpuart_rx_hold.sv
module mpuart_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fr_done,
  input  logic              accept,
  input  logic [DATA_W-1:0] fr_data,
  input  logic              fr_b9,
  input  logic              fr_err,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_frame_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid     <= 1'b0;
      rx_data      <= '0;
      rx_bit9      <= 1'b0;
      rx_frame_err <= 1'b0;
    end else if (fr_done && accept && !rx_valid) begin
      rx_valid     <= 1'b1;
      rx_data      <= fr_data;
      rx_bit9      <= fr_b9;
      rx_frame_err <= fr_err;
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  a_r13_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_bit9)));
endmodule

// File: rtl/mpuart_port.sv
module mpuart_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cfg_nine,
  input  logic       cfg_mp_en,
  input  logic [7:0] cfg_addr,
  input  logic [7:0] cfg_mask,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  input  logic       tx_bit9,
  output logic       tx_done,
  output logic       txd,
  input  logic       rxd,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       rx_frame_err
);
  localparam int DATA_W = 8;
  localparam int OSR    = 16;

  logic              fr_done, fr_b9, fr_err, accept, mp_active;
  logic [DATA_W-1:0] fr_data;

  assign mp_active = cfg_mp_en && cfg_nine;

  mpuart_tx #(.DATA_W(DATA_W), .OSR(OSR)) tx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .nine(cfg_nine),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_bit9(tx_bit9), .tx_done(tx_done), .txd(txd)
  );

  mpuart_rx #(.DATA_W(DATA_W), .OSR(OSR)) rx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .nine(cfg_nine),
    .fr_done(fr_done), .fr_data(fr_data), .fr_b9(fr_b9), .fr_err(fr_err)
  );

  mpuart_addr_filter #(.DATA_W(DATA_W)) filt_i (
    .mp_active(mp_active), .byte_in(fr_data), .b9_in(fr_b9),
    .node_addr(cfg_addr), .node_mask(cfg_mask), .accept(accept)
  );

  mpuart_rx_hold #(.DATA_W(DATA_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .fr_done(fr_done), .accept(accept),
    .fr_data(fr_data), .fr_b9(fr_b9), .fr_err(fr_err), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .rx_frame_err(rx_frame_err)
  );

  a_r2_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  a_r11_filter_needs_b9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_valid) && mp_active) |-> rx_bit9);
endmodule

// File: tb/mpuart_port_tb.sv
module mpuart_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic       cfg_nine = 1'b0, cfg_mp_en = 1'b0;
  logic [7:0] cfg_addr = 8'h00, cfg_mask = 8'h00;
  logic       tx_valid = 1'b0, tx_bit9 = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, tx_done, txd;
  logic       rxd_drv = 1'b1;
  logic       rx_valid, rx_bit9, rx_frame_err;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= ~tick;
  end

  mpuart_port dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_nine(cfg_nine),
    .cfg_mp_en(cfg_mp_en), .cfg_addr(cfg_addr), .cfg_mask(cfg_mask),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_bit9(tx_bit9), .tx_done(tx_done), .txd(txd), .rxd(rxd_drv),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .rx_frame_err(rx_frame_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_tick;
    do @(negedge clk); while (tick !== 1'b1);
  endtask

  task automatic pop;
    @(negedge clk) rx_ready = 1'b1;
    @(negedge clk) rx_ready = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] d, input logic b9, input logic stop_v, input int gbit);
    logic [10:0] fb;
    int n;
    n = cfg_nine ? 11 : 10;
    fb = {stop_v, (cfg_nine ? b9 : stop_v), d, 1'b0};
    if (cfg_nine) fb[10] = stop_v;
    for (int b = 0; b < n; b++)
      for (int i = 0; i < 16; i++) begin
        wait_tick;
        rxd_drv = (b == gbit && i == 7) ? ~fb[b] : fb[b];
      end
    wait_tick;
    rxd_drv = 1'b1;
    repeat (4) wait_tick;
  endtask

  task automatic tx_send_check(input logic [7:0] d, input logic b9, input string tag);
    logic [10:0] fb;
    int n;
    n = cfg_nine ? 11 : 10;
    fb = {1'b1, (cfg_nine ? b9 : 1'b1), d, 1'b0};
    @(negedge clk);
    tx_valid = 1'b1; tx_data = d; tx_bit9 = b9;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R3 tx_ready low while sending", {15'd0, tx_ready}, 16'd0);
    chk(tx_done == 1'b0, "R3 tx_done cleared on accept", {15'd0, tx_done}, 16'd0);
    while (txd !== 1'b0) @(negedge clk);
    repeat (8) wait_tick;
    for (int b = 0; b < n; b++) begin
      if (b > 0) repeat (16) wait_tick;
      chk(txd == fb[b], tag, {8'd0, 3'd0, b[4:0]}, {15'd0, fb[b]});
    end
    repeat (12) wait_tick;
    chk(tx_ready && tx_done, "R3 ready and done after stop", {14'd0, tx_ready, tx_done}, 16'd3);
  endtask

  task automatic expect_rx(input logic [7:0] d, input logic b9, input logic ferr, input string tag);
    chk(rx_valid == 1'b1, tag, {15'd0, rx_valid}, 16'd1);
    chk(rx_data == d && rx_bit9 == b9 && rx_frame_err == ferr, tag,
        {6'd0, rx_frame_err, rx_bit9, rx_data}, {6'd0, ferr, b9, d});
  endtask

  task automatic t_reset;
    chk(txd == 1'b1 && tx_ready == 1'b1 && tx_done == 1'b0 && rx_valid == 1'b0,
        "R1 reset state", {12'd0, txd, tx_ready, tx_done, rx_valid}, 16'b1100);
  endtask

  task automatic t_tx_modes;
    cfg_nine = 1'b0;
    tx_send_check(8'hA5, 1'b0, "R2 eight-bit tx bit");
    cfg_nine = 1'b1;
    tx_send_check(8'h3C, 1'b1, "R2 nine-bit tx bit");
    tx_send_check(8'hC3, 1'b0, "R2 nine-bit tx bit b9=0");
  endtask

  task automatic t_rx_basic;
    cfg_nine = 1'b0;
    rx_send(8'h96, 1'b0, 1'b1, -1);
    expect_rx(8'h96, 1'b0, 1'b0, "R4 eight-bit receive");
    repeat (40) @(negedge clk);
    expect_rx(8'h96, 1'b0, 1'b0, "R13 held without rx_ready");
    pop;
    chk(rx_valid == 1'b0, "R13 cleared by rx_ready", {15'd0, rx_valid}, 16'd0);
    cfg_nine = 1'b1;
    rx_send(8'h4B, 1'b1, 1'b1, -1);
    expect_rx(8'h4B, 1'b1, 1'b0, "R5 nine-bit receive");
    pop;
  endtask

  task automatic t_glitch;
    cfg_nine = 1'b0;
    rx_send(8'h0F, 1'b0, 1'b1, 2);
    expect_rx(8'h0F, 1'b0, 1'b0, "R6 glitch on bit 1");
    pop;
    rx_send(8'hF0, 1'b0, 1'b1, 8);
    expect_rx(8'hF0, 1'b0, 1'b0, "R6 glitch on bit 7");
    pop;
  endtask

  task automatic t_false_start;
    cfg_nine = 1'b0;
    for (int i = 0; i < 4; i++) begin wait_tick; rxd_drv = 1'b0; end
    wait_tick; rxd_drv = 1'b1;
    repeat (200) wait_tick;
    chk(rx_valid == 1'b0, "R7 short low pulse ignored", {15'd0, rx_valid}, 16'd0);
    rx_send(8'h6D, 1'b0, 1'b1, -1);
    expect_rx(8'h6D, 1'b0, 1'b0, "R7 next frame after false start");
    pop;
  endtask

  task automatic t_frame_err;
    cfg_nine = 1'b0;
    rx_send(8'h5C, 1'b0, 1'b0, -1);
    repeat (40) wait_tick;
    expect_rx(8'h5C, 1'b0, 1'b1, "R8 bad stop flagged");
    pop;
    rx_send(8'h5D, 1'b0, 1'b1, -1);
    expect_rx(8'h5D, 1'b0, 1'b0, "R8 good stop clean");
    pop;
  endtask

  task automatic t_double_and_overrun;
    cfg_nine = 1'b0;
    rx_send(8'h11, 1'b0, 1'b1, -1);
    fork
      rx_send(8'h22, 1'b0, 1'b1, -1);
      begin
        repeat (100) @(negedge clk);
        chk(rx_data == 8'h11 && rx_valid, "R9 first word held during second", {8'd0, rx_data}, 16'h11);
        pop;
      end
    join
    expect_rx(8'h22, 1'b0, 1'b0, "R9 second frame delivered");
    pop;
    rx_send(8'h33, 1'b0, 1'b1, -1);
    rx_send(8'h44, 1'b0, 1'b1, -1);
    expect_rx(8'h33, 1'b0, 1'b0, "R10 held word kept on overrun");
    pop;
    repeat (20) @(negedge clk);
    chk(rx_valid == 1'b0, "R10 overrun frame discarded", {15'd0, rx_valid}, 16'd0);
  endtask

  task automatic t_filter;
    cfg_nine = 1'b1; cfg_mp_en = 1'b1; cfg_addr = 8'h5A; cfg_mask = 8'hF0;
    rx_send(8'h53, 1'b1, 1'b1, -1);
    expect_rx(8'h53, 1'b1, 1'b0, "R11 masked address match");
    pop;
    rx_send(8'h63, 1'b1, 1'b1, -1);
    chk(rx_valid == 1'b0, "R11 mismatched address dropped", {15'd0, rx_valid}, 16'd0);
    rx_send(8'h53, 1'b0, 1'b1, -1);
    chk(rx_valid == 1'b0, "R11 data frame dropped while filtering", {15'd0, rx_valid}, 16'd0);
    rx_send(8'hF0, 1'b1, 1'b1, -1);
    expect_rx(8'hF0, 1'b1, 1'b0, "R12 broadcast accepted");
    pop;
    cfg_mp_en = 1'b0;
    rx_send(8'h63, 1'b0, 1'b1, -1);
    expect_rx(8'h63, 1'b0, 1'b0, "R11 filtering off accepts data");
    pop;
  endtask

  task automatic t_duplex;
    cfg_nine = 1'b1;
    fork
      tx_send_check(8'h81, 1'b1, "R14 tx bit during rx");
      rx_send(8'h7E, 1'b0, 1'b1, -1);
    join
    expect_rx(8'h7E, 1'b0, 1'b0, "R14 rx during tx");
    pop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_tx_modes;
    t_rx_basic;
    t_glitch;
    t_false_start;
    t_frame_err;
    t_double_and_overrun;
    t_filter;
    t_duplex;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule